// File: doc/BRIEF.md
# Integer ALU with byte swap

This block is the execution stage for the arithmetic instruction classes of a 64-bit register virtual machine. Each clock it takes one decoded arithmetic instruction (a 4-bit operation code, a bit that picks the immediate or the source register as the second operand, a bit that picks 32-bit or 64-bit operation, the 16-bit offset field and the 32-bit immediate) together with the current destination and source register values. One cycle later it presents the new destination value and a flag that marks an encoding this unit does not accept.

The operations are add, subtract, the low half of a multiply, the three bitwise operations, left, logical-right and arithmetic-right shifts, negate, move, a move with sign extension whose width comes from the offset field, and endian conversion or unconditional byte swap whose width comes from the immediate. Divide and modulo are executed elsewhere, so their codes are flagged here. A parameter sets the byte order of the host, which decides whether a conversion request actually reorders bytes.

When an encoding is flagged, the result equals the incoming destination value, so the register write-back can proceed without a special path.

Top module: `alu_exec`

## Requirements
- R1: Operation codes are add 0x0, subtract 0x1, multiply 0x2, OR 0x4, AND 0x5, left shift 0x6, logical right shift 0x7, negate 0x8, XOR 0xa, move 0xb, arithmetic right shift 0xc and endian 0xd; `src_sel` 0 takes the immediate as second operand, 1 takes `src_val`.
- R2: With `wide_mode` 1 the immediate is sign-extended from 32 to 64 bits before use.
- R3: With `wide_mode` 0 only the low 32 bits of each operand take part and the upper 32 result bits are zero, for every operation except endian.
- R4: Add, subtract and multiply wrap at the operating width; multiply returns the low half of the product.
- R5: The shift amount is the second operand masked to 6 bits in 64-bit mode and 5 bits in 32-bit mode; the arithmetic right shift fills with the sign bit of the operating width.
- R6: Negate returns the two's complement of the destination at the operating width and is legal only with `src_sel` 0.
- R7: Move with offset 8, 16 or 32 sign-extends that many low bits of `src_val`; it requires `src_sel` 1, offset 32 is legal only in 64-bit mode, and in 32-bit mode the extension reaches bit 31 with the upper half zero.
- R8: Endian with `wide_mode` 0 converts the destination to little-endian order for `src_sel` 0 and to big-endian order for `src_sel` 1; with the default little-endian host only the big-endian request reorders bytes.
- R9: Endian with `wide_mode` 1 reverses the byte order unconditionally and requires `src_sel` 0.
- R10: The endian width is the immediate value 16, 32 or 64; the result is the destination truncated to that width (reordered if required) and zero-extended to 64 bits; any other immediate is illegal.
- R11: Codes 0x3, 0x9, 0xe, 0xf, a nonzero offset on any operation other than the sign-extending move, and every other illegal combination above raise `illegal` and return `dst_val` unchanged.
- R12: Results appear one clock after the inputs; synchronous reset clears `result` and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Arithmetic operation code |
| src_sel | input | 1 | 0: immediate operand, 1: source register |
| wide_mode | input | 1 | 0: 32-bit operation, 1: 64-bit operation |
| offset | input | 16 | Offset field (sign-extension width for move) |
| imm | input | 32 | Immediate field (swap width for endian) |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| result | output | 64 | New destination value, one cycle later |
| illegal | output | 1 | Encoding rejected by this unit |

## Verification
The checker watches, on every cycle, that a flagged encoding hands back the previous destination value, that 32-bit non-endian results never carry upper bits, and that each forbidden pairing (negate with register source, 32-bit offset move in 32-bit mode, swap with register source in 64-bit mode, a bad swap width, divide or modulo codes) raises the flag. Arithmetic correctness, shift masking, sign fill, the choice between conversion and no-op under the host order, and truncation of narrow swaps are value properties that only the bench's reference model can judge, using random vectors and directed corner cases.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int IMM_W = 32;
    localparam int OFF_W = 16;
    localparam int OP_W  = 4;
    localparam int NUM_SWAP_W = 3;

    localparam logic [OP_W-1:0] OP_ADD  = 4'h0;
    localparam logic [OP_W-1:0] OP_SUB  = 4'h1;
    localparam logic [OP_W-1:0] OP_MUL  = 4'h2;
    localparam logic [OP_W-1:0] OP_OR   = 4'h4;
    localparam logic [OP_W-1:0] OP_AND  = 4'h5;
    localparam logic [OP_W-1:0] OP_LSH  = 4'h6;
    localparam logic [OP_W-1:0] OP_RSH  = 4'h7;
    localparam logic [OP_W-1:0] OP_NEG  = 4'h8;
    localparam logic [OP_W-1:0] OP_XOR  = 4'ha;
    localparam logic [OP_W-1:0] OP_MOV  = 4'hb;
    localparam logic [OP_W-1:0] OP_ARSH = 4'hc;
    localparam logic [OP_W-1:0] OP_END  = 4'hd;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_B8   = 2'd1,
        EXT_B16  = 2'd2,
        EXT_B32  = 2'd3
    } ext_e;

    typedef enum logic [1:0] {
        SW_16 = 2'd0,
        SW_32 = 2'd1,
        SW_64 = 2'd2
    } swap_w_e;

    typedef struct packed {
        logic             illegal;
        logic [OP_W-1:0]  op;
        logic             wide;
        logic [XLEN-1:0]  a;
        logic [XLEN-1:0]  b;
        ext_e             ext;
        swap_w_e          sw_width;
        logic             do_swap;
    } alu_req_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] v,
                                                  input logic sign);
        return sign ? {{(XLEN-IMM_W){v[IMM_W-1]}}, v} : {{(XLEN-IMM_W){1'b0}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext_from(input logic [XLEN-1:0] v,
                                                  input ext_e k);
        case (k)
            EXT_B8:  return {{(XLEN-8){v[7]}}, v[7:0]};
            EXT_B16: return {{(XLEN-16){v[15]}}, v[15:0]};
            EXT_B32: return {{(XLEN-32){v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
    import alu_exec_pkg::*;
#(
    parameter bit HOST_BIG = 1'b0
) (
    input  logic [OP_W-1:0]  op_code,
    input  logic             src_sel,
    input  logic             wide_mode,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    output alu_req_t         req
);

    logic off_zero;
    logic imm_w16, imm_w32, imm_w64;

    assign off_zero = (offset == '0);
    assign imm_w16  = (imm == IMM_W'(16));
    assign imm_w32  = (imm == IMM_W'(32));
    assign imm_w64  = (imm == IMM_W'(64));

    always_comb begin
        req          = '0;
        req.op       = op_code;
        req.wide     = wide_mode;
        req.a        = dst_val;
        req.b        = src_sel ? src_val : widen_imm(imm, wide_mode);
        req.ext      = EXT_NONE;
        req.sw_width = SW_16;
        req.do_swap  = 1'b0;
        req.illegal  = 1'b0;

        case (op_code)
            OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND, OP_LSH, OP_RSH,
            OP_XOR, OP_ARSH: begin
                req.illegal = !off_zero;
            end
            OP_NEG: begin
                req.illegal = !off_zero || src_sel;
            end
            OP_MOV: begin
                if (off_zero) begin
                    req.ext = EXT_NONE;
                end else if (offset == OFF_W'(8)) begin
                    req.ext = EXT_B8;
                end else if (offset == OFF_W'(16)) begin
                    req.ext = EXT_B16;
                end else if (offset == OFF_W'(32) && wide_mode) begin
                    req.ext = EXT_B32;
                end else begin
                    req.illegal = 1'b1;
                end
                if (!off_zero && !src_sel) begin
                    req.illegal = 1'b1;
                end
            end
            OP_END: begin
                if (imm_w64)      req.sw_width = SW_64;
                else if (imm_w32) req.sw_width = SW_32;
                else              req.sw_width = SW_16;
                req.illegal = !off_zero || !(imm_w16 || imm_w32 || imm_w64)
                            || (wide_mode && src_sel);
                // Conversion reorders only when the target order differs from the host.
                req.do_swap = wide_mode ? 1'b1 : (src_sel != HOST_BIG);
            end
            default: begin
                req.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/alu_exec_arith.sv
module alu_exec_arith
    import alu_exec_pkg::*;
(
    input  alu_req_t        req,
    output logic [XLEN-1:0] y
);

    logic [XLEN-1:0] a64, b64, r64;
    logic [HALF-1:0] a32, b32, r32;
    logic [5:0]      sh64;
    logic [4:0]      sh32;
    logic [XLEN-1:0] mov_ext64;

    assign a64  = req.a;
    assign b64  = req.b;
    assign a32  = req.a[HALF-1:0];
    assign b32  = req.b[HALF-1:0];
    assign sh64 = req.b[5:0];
    assign sh32 = req.b[4:0];
    assign mov_ext64 = sext_from(req.b, req.ext);

    always_comb begin
        case (req.op)
            OP_ADD:  r64 = a64 + b64;
            OP_SUB:  r64 = a64 - b64;
            OP_MUL:  r64 = a64 * b64;
            OP_OR:   r64 = a64 | b64;
            OP_AND:  r64 = a64 & b64;
            OP_XOR:  r64 = a64 ^ b64;
            OP_LSH:  r64 = a64 << sh64;
            OP_RSH:  r64 = a64 >> sh64;
            OP_ARSH: r64 = XLEN'($signed(a64) >>> sh64);
            OP_NEG:  r64 = '0 - a64;
            OP_MOV:  r64 = mov_ext64;
            default: r64 = a64;
        endcase
    end

    always_comb begin
        case (req.op)
            OP_ADD:  r32 = a32 + b32;
            OP_SUB:  r32 = a32 - b32;
            OP_MUL:  r32 = a32 * b32;
            OP_OR:   r32 = a32 | b32;
            OP_AND:  r32 = a32 & b32;
            OP_XOR:  r32 = a32 ^ b32;
            OP_LSH:  r32 = a32 << sh32;
            OP_RSH:  r32 = a32 >> sh32;
            OP_ARSH: r32 = HALF'($signed(a32) >>> sh32);
            OP_NEG:  r32 = '0 - a32;
            OP_MOV:  r32 = mov_ext64[HALF-1:0];
            default: r32 = a32;
        endcase
    end

    assign y = req.wide ? r64 : {{(XLEN-HALF){1'b0}}, r32};

endmodule

// File: rtl/alu_exec_endian.sv
module alu_exec_endian
    import alu_exec_pkg::*;
(
    input  logic [XLEN-1:0] value,
    input  swap_w_e         sw_width,
    input  logic            do_swap,
    output logic [XLEN-1:0] y
);

    logic [XLEN-1:0] cand [NUM_SWAP_W];

    for (genvar g = 0; g < NUM_SWAP_W; g++) begin : g_width
        localparam int NB = 2 << g;
        logic [XLEN-1:0] swapped, kept;
        always_comb begin
            swapped = '0;
            kept    = '0;
            for (int i = 0; i < NB; i++) begin
                swapped[8*i +: 8] = value[8*(NB-1-i) +: 8];
                kept[8*i +: 8]    = value[8*i +: 8];
            end
        end
        assign cand[g] = do_swap ? swapped : kept;
    end

    always_comb begin
        case (sw_width)
            SW_32:   y = cand[1];
            SW_64:   y = cand[2];
            default: y = cand[0];
        endcase
    end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_exec_pkg::*;
#(
    parameter bit HOST_BIG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic              src_sel,
    input  logic              wide_mode,
    input  logic [15:0]       offset,
    input  logic [31:0]       imm,
    input  logic [63:0]       dst_val,
    input  logic [63:0]       src_val,
    output logic [63:0]       result,
    output logic              illegal
);

    alu_req_t        req;
    logic [XLEN-1:0] arith_y, end_y, next_y;

    alu_exec_decode #(.HOST_BIG(HOST_BIG)) u_dec (
        .op_code   (op_code),
        .src_sel   (src_sel),
        .wide_mode (wide_mode),
        .offset    (offset),
        .imm       (imm),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .req       (req)
    );

    alu_exec_arith u_arith (
        .req (req),
        .y   (arith_y)
    );

    alu_exec_endian u_end (
        .value    (req.a),
        .sw_width (req.sw_width),
        .do_swap  (req.do_swap),
        .y        (end_y)
    );

    always_comb begin
        if (req.illegal)          next_y = req.a;
        else if (req.op == OP_END) next_y = end_y;
        else                       next_y = arith_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            illegal <= 1'b0;
        end else begin
            result  <= next_y;
            illegal <= req.illegal;
        end
    end

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_code,
    input logic        src_sel,
    input logic        wide_mode,
    input logic [15:0] offset,
    input logic [31:0] imm,
    input logic [63:0] dst_val,
    input logic [63:0] result,
    input logic        illegal
);

    a_r11_flag_keeps_dst: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'h3 || op_code == 4'h9 || op_code == 4'he || op_code == 4'hf)
        |=> (illegal && result == $past(dst_val)));

    a_r11_offset_misuse: assert property (@(posedge clk) disable iff (rst)
        (op_code != 4'hb && offset != 16'h0) |=> (illegal && result == $past(dst_val)));

    a_r3_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (!wide_mode && op_code != 4'hd) |=> (illegal || result[63:32] == 32'h0));

    a_r6_neg_reg_flag: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'h8 && src_sel) |=> illegal);

    a_r7_narrow_w32_flag: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'hb && !wide_mode && offset == 16'd32) |=> illegal);

    a_r9_wide_swap_src_flag: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'hd && wide_mode && src_sel) |=> illegal);

    a_r10_bad_width_flag: assert property (@(posedge clk) disable iff (rst)
        (op_code == 4'hd && imm != 32'd16 && imm != 32'd32 && imm != 32'd64) |=> illegal);

    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (result == 64'h0 && !illegal));

endmodule

bind alu_exec alu_exec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_code   (op_code),
    .src_sel   (src_sel),
    .wide_mode (wide_mode),
    .offset    (offset),
    .imm       (imm),
    .dst_val   (dst_val),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/sim_alu_exec.sv
module sim_alu_exec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = '0;
    logic        src_sel = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [63:0] result;
    logic        illegal;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alu_exec u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .src_sel(src_sel),
        .wide_mode(wide_mode), .offset(offset), .imm(imm),
        .dst_val(dst_val), .src_val(src_val), .result(result), .illegal(illegal)
    );

    // Reference model written from the requirements; host is little-endian.
    function automatic logic [64:0] model(input logic [3:0] op, input logic s,
        input logic w, input logic [15:0] off, input logic [31:0] im,
        input logic [63:0] d, input logic [63:0] sv);
        logic        bad;
        logic [63:0] b, r;
        logic [31:0] d32, b32, r32;
        int          nb;
        logic        sw;
        bad = 1'b0;
        case (op)
            4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h7, 4'ha, 4'hc: bad = (off != 0);
            4'h8: bad = (off != 0) || s;
            4'hb: bad = (off != 0) && !(s && (off == 8 || off == 16 || (off == 32 && w)));
            4'hd: bad = (off != 0) || !(im == 16 || im == 32 || im == 64) || (w && s);
            default: bad = 1'b1;
        endcase
        if (bad) return {1'b1, d};
        b = s ? sv : (w ? {{32{im[31]}}, im} : {32'h0, im});
        d32 = d[31:0];
        b32 = b[31:0];
        r = 64'h0;
        r32 = 32'h0;
        if (op == 4'hd) begin
            nb = im / 8;
            sw = w || s;
            for (int i = 0; i < nb; i++)
                r[8*i +: 8] = sw ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
            return {1'b0, r};
        end
        case (op)
            4'h0: begin r = d + b; r32 = d32 + b32; end
            4'h1: begin r = d - b; r32 = d32 - b32; end
            4'h2: begin r = d * b; r32 = d32 * b32; end
            4'h4: begin r = d | b; r32 = d32 | b32; end
            4'h5: begin r = d & b; r32 = d32 & b32; end
            4'ha: begin r = d ^ b; r32 = d32 ^ b32; end
            4'h6: begin r = d << (b & 64'h3f); r32 = d32 << (b32 & 32'h1f); end
            4'h7: begin r = d >> (b & 64'h3f); r32 = d32 >> (b32 & 32'h1f); end
            4'hc: begin
                r = d;
                for (int k = 0; k < int'(b[5:0]); k++) r = {r[63], r[63:1]};
                r32 = d32;
                for (int k = 0; k < int'(b32[4:0]); k++) r32 = {r32[31], r32[31:1]};
            end
            4'h8: begin r = 64'h0 - d; r32 = 32'h0 - d32; end
            default: begin
                if (off == 8)       begin r = {{56{b[7]}}, b[7:0]};   r32 = {{24{b[7]}}, b[7:0]}; end
                else if (off == 16) begin r = {{48{b[15]}}, b[15:0]}; r32 = {{16{b[15]}}, b[15:0]}; end
                else if (off == 32) begin r = {{32{b[31]}}, b[31:0]}; r32 = b32; end
                else                begin r = b; r32 = b32; end
            end
        endcase
        return {1'b0, w ? r : {32'h0, r32}};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic [15:0] off);
        case (op)
            4'h0, 4'h1, 4'h2: return "R4";
            4'h4, 4'h5, 4'ha: return "R1";
            4'h6, 4'h7, 4'hc: return "R5";
            4'h8:             return "R6";
            4'hb:             return (off != 0) ? "R7" : "R1";
            4'hd:             return "R10";
            default:          return "R11";
        endcase
    endfunction

    task automatic check_now(input string tag, input logic [64:0] exp);
        n_vec++;
        if ({illegal, result} !== exp) begin
            n_bad++;
            $display("FAIL %s: got ill=%0b res=%h, expected ill=%0b res=%h",
                     tag, illegal, result, exp[64], exp[63:0]);
        end
    endtask

    task automatic run(input string tag, input logic [3:0] op, input logic s,
        input logic w, input logic [15:0] off, input logic [31:0] im,
        input logic [63:0] d, input logic [63:0] sv);
        op_code = op; src_sel = s; wide_mode = w; offset = off; imm = im;
        dst_val = d; src_val = sv;
        @(negedge clk);
        check_now(tag, model(op, s, w, off, im, d, sv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check_now("R12", 65'h0);
        rst = 1'b0;

        // R1 / R2: immediate forms
        run("R2", 4'h0, 1'b0, 1'b1, 16'h0, 32'hffff_fffe, 64'h10, 64'h0);
        run("R1", 4'hb, 1'b0, 1'b0, 16'h0, 32'h8000_0000, 64'h1234, 64'h0);
        run("R1", 4'ha, 1'b1, 1'b1, 16'h0, 32'h0, 64'hff00_ff00_ff00_ff00, 64'h0ff0_0ff0_0ff0_0ff0);
        // R3 / R4: 32-bit wrap clears upper half
        run("R3", 4'h0, 1'b1, 1'b0, 16'h0, 32'h0, 64'hdead_beef_ffff_ffff, 64'h1);
        run("R4", 4'h2, 1'b1, 1'b1, 16'h0, 32'h0, 64'hffff_ffff_ffff_ffff, 64'h3);
        // R5: shift masking and sign fill
        run("R5", 4'hc, 1'b0, 1'b1, 16'h0, 32'd127, 64'h8000_0000_0000_0000, 64'h0);
        run("R5", 4'hc, 1'b0, 1'b0, 16'h0, 32'd36, 64'h0000_0000_8000_0000, 64'h0);
        run("R5", 4'h6, 1'b1, 1'b0, 16'h0, 32'h0, 64'h1, 64'h21);
        // R6: negate
        run("R6", 4'h8, 1'b0, 1'b0, 16'h0, 32'h0, 64'h5, 64'h0);
        run("R6", 4'h8, 1'b1, 1'b1, 16'h0, 32'h0, 64'h5, 64'h0);
        // R7: sign-extending move
        run("R7", 4'hb, 1'b1, 1'b1, 16'd32, 32'h0, 64'h0, 64'h0000_0000_8000_0001);
        run("R7", 4'hb, 1'b1, 1'b0, 16'd8, 32'h0, 64'h0, 64'h80);
        run("R7", 4'hb, 1'b1, 1'b0, 16'd32, 32'h0, 64'h77, 64'h1);
        run("R7", 4'hb, 1'b0, 1'b1, 16'd16, 32'h0, 64'h77, 64'h1);
        // R8 / R9 / R10: endian
        run("R8", 4'hd, 1'b1, 1'b0, 16'h0, 32'd16, 64'haaaa_bbbb_cccc_1234, 64'h0);
        run("R8", 4'hd, 1'b0, 1'b0, 16'h0, 32'd32, 64'haaaa_bbbb_1122_3344, 64'h0);
        run("R9", 4'hd, 1'b0, 1'b1, 16'h0, 32'd64, 64'h0102_0304_0506_0708, 64'h0);
        run("R9", 4'hd, 1'b1, 1'b1, 16'h0, 32'd64, 64'h0102_0304_0506_0708, 64'h0);
        run("R10", 4'hd, 1'b0, 1'b0, 16'h0, 32'd48, 64'h99, 64'h0);
        run("R10", 4'hd, 1'b1, 1'b0, 16'h0, 32'd64, 64'h0102_0304_0506_0708, 64'h0);
        // R11: divide/modulo codes and offset misuse
        run("R11", 4'h3, 1'b1, 1'b1, 16'h0, 32'h0, 64'hcafe, 64'h2);
        run("R11", 4'h0, 1'b1, 1'b1, 16'h1, 32'h0, 64'hbeef, 64'h2);

        // Random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            logic [3:0]  op;
            logic [15:0] off;
            logic [31:0] im;
            int          pick;
            op   = 4'($urandom);
            pick = $urandom_range(0, 9);
            off  = (pick < 6) ? 16'h0 : (pick == 6) ? 16'd8 : (pick == 7) ? 16'd16 :
                   (pick == 8) ? 16'd32 : 16'($urandom);
            im   = $urandom;
            if (op == 4'hd && $urandom_range(0, 3) != 0)
                im = 32'd16 << $urandom_range(0, 2);
            run(tag_of(op, off), op, 1'($urandom), 1'($urandom), off, im,
                {$urandom, $urandom}, {$urandom, $urandom});
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule